// File: doc/BRIEF.md
# Strobed 8-bit Parallel Port

This block is a fixed-function byte port. A holding register takes its value from the 8-bit data input while a capture condition is true, and that register drives the 8-bit data output. A mode input picks the capture condition. With mode 0, a peripheral's strobe loads the register. With mode 1, the processor's device-select combination loads it. A strobe falling edge sets a service-request flag, and that flag drives an active-low interrupt toward the processor. Selecting the device, which is how the processor reads the port, clears the flag.

The whole block runs on one system clock. The strobe and the two select pins pass through a two-stage synchronizer, and edges are detected on the synchronized samples. The output-enable signal tells a pad ring when to drive the port's byte onto a shared bus. An active-low clear acts asynchronously. It empties the holding register and drops the request.

Top module: `strobed_port`

## Requirements
- R1: While clr_n is low, and after it is released, dout is 0x00 and irq_n is 1.
- R2: With mode = 0, dout follows din on every clock while the synchronized strobe is high. A strobe level driven before rising edge k appears at dout after edge k+2.
- R3: With mode = 1, dout follows din on every clock while the synchronized device select is true.
- R4: The strobe has no effect on dout with mode = 1. The device select has no effect on dout with mode = 0. With the capture condition false, dout holds its value.
- R5: A high-to-low transition of the synchronized strobe, in either mode, sets the service-request flag. irq_n is 0 exactly while the flag is set and the device is not selected.
- R6: Device selection clears the flag on the next clock. A strobe fall seen while the device is selected leaves the flag clear.
- R7: A rising strobe edge never sets the flag.
- R8: oe is 1 when mode = 1 or the synchronized device select is true, and 0 otherwise.
- R9: The device is selected only when sel_a_n = 0 and sel_b = 1. The other three pin combinations neither select nor capture.
- R10: clr_n going low clears dout and the flag at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Asynchronous active-low clear |
| mode | input | 1 | Capture source: 0 selects the strobe, 1 selects the device select |
| stb | input | 1 | Peripheral strobe, asynchronous |
| sel_a_n | input | 1 | Device select, active low, asynchronous |
| sel_b | input | 1 | Device select, active high, asynchronous |
| din | input | 8 | Data byte in |
| dout | output | 8 | Holding register contents |
| oe | output | 1 | Output enable for the pad ring |
| irq_n | output | 1 | Active-low service request |

## Verification
The bench targets four corner cases.
- It moves din while the strobe is still inside the synchronizer. An off-by-one latency then shows up as a wrong byte.
- It lets the strobe fall while the device is selected. A design that gives the set priority over the clear would leave a stale interrupt asserted after deselection.
- It drives each partial select combination and each wrong-mode capture source. A design with a loose select decode or a loose mode mux would overwrite the held byte.
- It pulls clr_n low between clock edges. A synchronous clear would still show old data at that moment.

// File: rtl/strobed_port_pkg.sv
`timescale 1ns/1ps
package strobed_port_pkg;
    localparam int PORT_W = 8;

    typedef logic [PORT_W-1:0] port_byte_t;

    typedef struct packed {
        logic stb_prev;
        logic srq;
    } srq_state_t;
endpackage

// File: rtl/strobed_port_sync.sv
`timescale 1ns/1ps
module strobed_port_sync #(
    parameter int              WIDTH     = 3,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/strobed_port_hold.sv
`timescale 1ns/1ps
module strobed_port_hold
    import strobed_port_pkg::*;
(
    input  logic       clk,
    input  logic       clr_n,
    input  logic       load,
    input  port_byte_t din,
    output port_byte_t hold
);
    port_byte_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (load) begin
            hold_d = din;
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign hold = hold_q;
endmodule

// File: rtl/strobed_port_srq.sv
`timescale 1ns/1ps
module strobed_port_srq
    import strobed_port_pkg::*;
(
    input  logic clk,
    input  logic clr_n,
    input  logic stb_s,
    input  logic sel_s,
    output logic srq
);
    srq_state_t st_d, st_q;
    logic       fall;

    always_comb begin
        fall        = st_q.stb_prev && !stb_s;
        st_d        = st_q;
        st_d.stb_prev = stb_s;
        if (sel_s) begin
            st_d.srq = 1'b0;
        end else if (fall) begin
            st_d.srq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign srq = st_q.srq;
endmodule

// File: rtl/strobed_port.sv
`timescale 1ns/1ps
module strobed_port
    import strobed_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              mode,
    input  logic              stb,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic [PORT_W-1:0] din,
    output logic [PORT_W-1:0] dout,
    output logic              oe,
    output logic              irq_n
);
    localparam int              CTRL_W   = 3;
    localparam logic [CTRL_W-1:0] CTRL_RST = 3'b010;

    logic [CTRL_W-1:0] ctrl_raw, ctrl_s;
    logic              stb_s, sel_s, load, srq;

    assign ctrl_raw = {sel_b, sel_a_n, stb};

    strobed_port_sync #(
        .WIDTH    (CTRL_W),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(CTRL_RST)
    ) u_sync (
        .clk  (clk),
        .clr_n(clr_n),
        .d    (ctrl_raw),
        .q    (ctrl_s)
    );

    assign stb_s = ctrl_s[0];
    assign sel_s = !ctrl_s[1] && ctrl_s[2];
    assign load  = mode ? sel_s : stb_s;

    strobed_port_hold u_hold (
        .clk  (clk),
        .clr_n(clr_n),
        .load (load),
        .din  (din),
        .hold (dout)
    );

    strobed_port_srq u_srq (
        .clk  (clk),
        .clr_n(clr_n),
        .stb_s(stb_s),
        .sel_s(sel_s),
        .srq  (srq)
    );

    assign oe    = mode || sel_s;
    assign irq_n = !(srq && !sel_s);
endmodule

// File: rtl/strobed_port_props.sv
`timescale 1ns/1ps
module strobed_port_props
    import strobed_port_pkg::*;
(
    input logic       clk,
    input logic       clr_n,
    input logic       mode,
    input port_byte_t din,
    input port_byte_t dout,
    input logic       oe,
    input logic       irq_n,
    input logic       stb_s,
    input logic       sel_s
);
    p_release_clean_r1: assert property (@(posedge clk)
        $rose(clr_n) |-> (dout == '0) && irq_n);

    p_capture_strobe_r2: assert property (@(posedge clk) disable iff (!clr_n)
        (!mode && stb_s) |=> dout == $past(din));

    p_capture_select_r3: assert property (@(posedge clk) disable iff (!clr_n)
        (mode && sel_s) |=> dout == $past(din));

    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (mode ? !sel_s : !stb_s) |=> $stable(dout));

    p_fall_sets_r5: assert property (@(posedge clk) disable iff (!clr_n)
        ($fell(stb_s) && !sel_s) |=> (!irq_n || sel_s));

    p_select_clears_r6: assert property (@(posedge clk) disable iff (!clr_n)
        sel_s |=> irq_n);

    p_rise_quiet_r7: assert property (@(posedge clk) disable iff (!clr_n)
        ($rose(stb_s) && irq_n) |=> irq_n);

    p_mode_enables_r8: assert property (@(posedge clk) disable iff (!clr_n)
        mode |-> oe);
endmodule

bind strobed_port strobed_port_props u_props (
    .clk  (clk),
    .clr_n(clr_n),
    .mode (mode),
    .din  (din),
    .dout (dout),
    .oe   (oe),
    .irq_n(irq_n),
    .stb_s(stb_s),
    .sel_s(sel_s)
);

// File: tb/strobed_port_bench.sv
`timescale 1ns/1ps
module strobed_port_bench;
    logic       clk = 1'b0;
    logic       clr_n;
    logic       mode, stb, sel_a_n, sel_b;
    logic [7:0] din;
    logic [7:0] dout;
    logic       oe, irq_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    strobed_port u_strobed_port (
        .clk    (clk),
        .clr_n  (clr_n),
        .mode   (mode),
        .stb    (stb),
        .sel_a_n(sel_a_n),
        .sel_b  (sel_b),
        .din    (din),
        .dout   (dout),
        .oe     (oe),
        .irq_n  (irq_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: pin samples pushed into queues, two-deep delay
    bit        q_stb[$]  = '{0, 0};
    bit        q_seln[$] = '{1, 1};
    bit        q_selb[$] = '{0, 0};
    bit        m_prev = 0;
    bit        m_flag = 0;
    int        m_byte = 0;

    always @(posedge clk) begin
        if (!clr_n) begin
            q_stb  = '{0, 0};
            q_seln = '{1, 1};
            q_selb = '{0, 0};
            m_prev = 0; m_flag = 0; m_byte = 0;
        end else begin
            bit s_stb, s_sel;
            s_stb = q_stb[0];
            s_sel = (q_seln[0] == 0) && (q_selb[0] == 1);
            if (mode ? s_sel : s_stb) m_byte = din;
            if (s_sel) m_flag = 0;
            else if (m_prev && !s_stb) m_flag = 1;
            m_prev = s_stb;
            void'(q_stb.pop_front());  q_stb.push_back(stb);
            void'(q_seln.pop_front()); q_seln.push_back(sel_a_n);
            void'(q_selb.pop_front()); q_selb.push_back(sel_b);
        end
        #5;
        if (!done) begin
            bit now_sel;
            now_sel = (q_seln[0] == 0) && (q_selb[0] == 1);
            check("R2 model dout", dout, m_byte);
            check("R5 model irq_n", irq_n, !(m_flag && !now_sel));
            check("R8 model oe", oe, mode || now_sel);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        clr_n = 1'b0; mode = 1'b0; stb = 1'b0;
        sel_a_n = 1'b1; sel_b = 1'b0; din = 8'h00;
        cyc(3);
        check("R1 reset dout", dout, 8'h00);
        check("R1 reset irq_n", irq_n, 1);
        check("R8 reset oe", oe, 0);
        clr_n = 1'b1;
        cyc(2);

        // R2: strobe capture, following din while high
        din = 8'hA5; stb = 1'b1;
        cyc(3);
        check("R2 strobe capture", dout, 8'hA5);
        din = 8'h5A;
        cyc(1);
        check("R2 follows din", dout, 8'h5A);
        check("R7 rise no request", irq_n, 1);
        stb = 1'b0;
        cyc(3);
        din = 8'hFF;
        cyc(2);
        check("R4 strobe low holds", dout, 8'h5A);
        check("R5 fall requests", irq_n, 0);

        // R6: selection clears, mode 0 select does not capture
        sel_a_n = 1'b0; sel_b = 1'b1;
        cyc(3);
        check("R8 select enables", oe, 1);
        check("R6 select masks", irq_n, 1);
        check("R4 select ignored mode0", dout, 8'h5A);
        sel_a_n = 1'b1; sel_b = 1'b0;
        cyc(3);
        check("R6 flag cleared", irq_n, 1);
        check("R8 deselect", oe, 0);

        // R9: partial select combinations
        sel_a_n = 1'b0; sel_b = 1'b0;
        cyc(3);
        check("R9 a low b low", oe, 0);
        sel_a_n = 1'b1; sel_b = 1'b1;
        cyc(3);
        check("R9 a high b high", oe, 0);
        sel_b = 1'b0;

        // R3: device-select capture
        mode = 1'b1; din = 8'hC3;
        cyc(1);
        check("R8 mode enables", oe, 1);
        check("R4 unselected holds", dout, 8'h5A);
        sel_a_n = 1'b0; sel_b = 1'b0;
        cyc(3);
        check("R9 partial no capture", dout, 8'h5A);
        sel_b = 1'b1;
        cyc(3);
        check("R3 select capture", dout, 8'hC3);
        sel_a_n = 1'b1; sel_b = 1'b0;
        cyc(3);
        din = 8'h3C; stb = 1'b1;
        cyc(4);
        stb = 1'b0;
        cyc(4);
        check("R4 strobe ignored mode1", dout, 8'hC3);
        check("R5 fall requests mode1", irq_n, 0);

        // R6: strobe falls while selected
        mode = 1'b0;
        sel_a_n = 1'b0; sel_b = 1'b1; stb = 1'b1;
        cyc(4);
        stb = 1'b0;
        cyc(4);
        sel_a_n = 1'b1; sel_b = 1'b0;
        cyc(3);
        check("R6 fall while selected", irq_n, 1);

        // R10: asynchronous clear between edges
        stb = 1'b1;
        cyc(4);
        stb = 1'b0;
        cyc(4);
        check("R5 request before clear", irq_n, 0);
        check("R2 byte before clear", dout, 8'h3C);
        clr_n = 1'b0;
        #2;
        check("R10 async dout", dout, 8'h00);
        check("R10 async irq_n", irq_n, 1);
        cyc(2);
        clr_n = 1'b1;
        cyc(2);
        check("R1 after release", dout, 8'h00);
        check("R1 irq after release", irq_n, 1);
        finish_run();
    end
endmodule